// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block collects interrupt requests from on-chip sources and from two external active-low request lines. It keeps them in a 14-bit request register and gates them with a 15-bit enable register. From the requests that are both pending and enabled it forms one priority level from 1 to 6. That level drives the processor's three active-low priority pins. The block never presents level 7, the non-maskable level.

Software reaches both registers over a small register bus. Each register has one write-only address and one read-only address. Every write carries a set/clear flag in its top bit. The other data bits select which register bits the write changes. Bits that are not selected keep their value, so different handlers can change their own bits without a read-modify-write.

The two external lines each pass through a two-flop synchronizer. While a line is held low it keeps its request bit set. Software acknowledges any interrupt by clearing its request bit.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset both registers hold zero, `ipl_n` is 3'b111, and both read addresses return 0.
- R2: The addresses decode as follows: 0 writes the enable register, 1 reads the enable register, 2 writes the request register and 3 reads the request register. A read at address 0 or 2 returns 0. Read data bit 15 is always 0.
- R3: A write with bit 15 = 1 sets each register bit whose data bit is 1. All other bits are left unchanged, and bit 15 is not stored.
- R4: A write with bit 15 = 0 clears each register bit whose data bit is 1. All other bits are left unchanged.
- R5: The request register stores bits 13..0 only and uses the same set/clear writes. Data bit 14 has no effect on it, and it reads back as 0.
- R6: A high on `src_set[i]` at a clock edge sets request bit i. When this coincides with a clear of the same bit, the set wins. `src_set[3]` and `src_set[13]` are ignored.
- R7: While `ext_lo_n` is low, request bit 3 is set. The bit first reads as set after the third rising edge that follows the fall, and clears do not take effect while the line stays low.
- R8: `ext_hi_n` behaves in the same way for request bit 13.
- R9: Request bits map to levels as follows: bits 0..2 are level 1, bit 3 is level 2, bits 4..5 are level 3, bits 6..10 are level 4, bits 11..12 are level 5 and bit 13 is level 6.
- R10: The output level is the highest level among request bits that are both pending and enabled. `ipl_n` carries the inverted level, so it reads 3'b111 when nothing is pending.
- R11: A request whose enable bit is clear has no effect on the output level.
- R12: Enable bit 14 is a master enable. While it is 0, `ipl_n` is 3'b111.
- R13: `ipl_n` follows a register change one rising edge later, and it is never 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data; bit 15 selects set (1) or clear (0) |
| bus_rdata | output | 16 | Combinational read data |
| src_set | input | 14 | On-chip request set pulses, one per request bit |
| ext_lo_n | input | 1 | External low-priority request, active low |
| ext_hi_n | input | 1 | External high-priority request, active low |
| ipl_n | output | 3 | Priority level to the processor, active low |

## Verification
Each result has a fixed latency. Read data is combinational, so the bench samples it one time step after it sets the address. A register write or a `src_set` pulse lands at the next rising edge, and `ipl_n` follows one edge after that. An external line fall reaches the request register on the third edge and `ipl_n` on the fourth. The bench drives all inputs on falling edges and samples at the falling edge that follows the edge where a result is due. For the external lines it also checks that the request bit is still clear one edge too early.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DW         = 16;
  localparam int SET_BIT    = 15;
  localparam int MASTER_BIT = 14;
  localparam int EN_W       = 15;
  localparam int REQ_W      = 14;
  localparam int EXT_LO_BIT = 3;
  localparam int EXT_HI_BIT = 13;
  localparam int LVL_W      = 3;

  typedef enum logic [1:0] {
    A_EN_WR  = 2'd0,
    A_EN_RD  = 2'd1,
    A_REQ_WR = 2'd2,
    A_REQ_RD = 2'd3
  } reg_addr_e;

  function automatic logic [LVL_W-1:0] bit_level(input int idx);
    if (idx <= 2)       return 3'd1;
    else if (idx == 3)  return 3'd2;
    else if (idx <= 5)  return 3'd3;
    else if (idx <= 10) return 3'd4;
    else if (idx <= 12) return 3'd5;
    else                return 3'd6;
  endfunction

  function automatic logic [LVL_W-1:0] top_level(input logic [REQ_W-1:0] act);
    logic [LVL_W-1:0] best;
    best = '0;
    for (int i = 0; i < REQ_W; i++)
      if (act[i] && bit_level(i) > best) best = bit_level(i);
    return best;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_n,
  output logic [N-1:0] q_n
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= d_n;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q_n = stg[STAGES-1];
endmodule

// File: rtl/irq_setclr_reg.sv
module irq_setclr_reg #(
  parameter int W       = 15,
  parameter int DW      = 16,
  parameter int SET_BIT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [W-1:0]  hw_set,
  output logic [W-1:0]  q
);
  logic [W-1:0] sel;
  logic         do_set;
  logic [W-1:0] after_wr;

  assign sel    = wdata[W-1:0];
  assign do_set = wdata[SET_BIT];

  always_comb begin
    after_wr = q;
    if (wr_en) after_wr = do_set ? (q | sel) : (q & ~sel);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= after_wr | hw_set;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && do_set |=> (q & $past(sel)) == $past(sel)); // R3
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !do_set && hw_set == '0 |=> (q & $past(sel)) == '0); // R4
  AST_KEEP_UNSEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hw_set == '0 |=> ((q ^ $past(q)) & ~$past(sel)) == '0); // R3
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
(
  input  logic [REQ_W-1:0] req,
  input  logic [EN_W-1:0]  en,
  output logic [LVL_W-1:0] level
);
  logic             master_on;
  logic [REQ_W-1:0] active;

  assign master_on = en[MASTER_BIT];
  assign active    = master_on ? (req & en[REQ_W-1:0]) : '0;
  assign level     = top_level(active);

  always_comb begin
    AST_LEVEL_RANGE: assert (level <= 3'd6); // R13
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [REQ_W-1:0] src_set,
  input  logic             ext_lo_n,
  input  logic             ext_hi_n,
  output logic [LVL_W-1:0] ipl_n
);
  localparam logic [REQ_W-1:0] ONCHIP_MASK =
    ~((REQ_W'(1) << EXT_LO_BIT) | (REQ_W'(1) << EXT_HI_BIT));

  logic [EN_W-1:0]  en_q;
  logic [REQ_W-1:0] req_q;
  logic [REQ_W-1:0] req_hw;
  logic [1:0]       ext_sync_n;
  logic             lo_sync_n, hi_sync_n;
  logic             en_wr, req_wr;
  logic [LVL_W-1:0] level;

  assign en_wr  = bus_wr && (bus_addr == A_EN_WR);
  assign req_wr = bus_wr && (bus_addr == A_REQ_WR);

  irq_sync #(.N(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_n({ext_hi_n, ext_lo_n}), .q_n(ext_sync_n));

  assign lo_sync_n = ext_sync_n[0];
  assign hi_sync_n = ext_sync_n[1];

  always_comb begin
    req_hw = src_set & ONCHIP_MASK;
    req_hw[EXT_LO_BIT] = !lo_sync_n;
    req_hw[EXT_HI_BIT] = !hi_sync_n;
  end

  irq_setclr_reg #(.W(EN_W), .DW(DW), .SET_BIT(SET_BIT)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_en(en_wr), .wdata(bus_wdata),
    .hw_set('0), .q(en_q));

  irq_setclr_reg #(.W(REQ_W), .DW(DW), .SET_BIT(SET_BIT)) u_req (
    .clk(clk), .rst_n(rst_n), .wr_en(req_wr), .wdata(bus_wdata),
    .hw_set(req_hw), .q(req_q));

  irq_prio_enc u_enc (.req(req_q), .en(en_q), .level(level));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ipl_n <= '1;
    else        ipl_n <= ~level;

  always_comb begin
    case (bus_addr)
      A_EN_RD:  bus_rdata = {{(DW-EN_W){1'b0}}, en_q};
      A_REQ_RD: bus_rdata = {{(DW-REQ_W){1'b0}}, req_q};
      default:  bus_rdata = '0;
    endcase
  end

  AST_NEVER_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_n != 3'b000); // R13
  AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q[MASTER_BIT] |=> ipl_n == 3'b111); // R12
  AST_MASKED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q & en_q[REQ_W-1:0]) == '0 |=> ipl_n == 3'b111); // R11
  AST_EXT_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_sync_n |=> req_q[EXT_LO_BIT]); // R7
  AST_EXT_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_sync_n |=> req_q[EXT_HI_BIT]); // R8
  AST_RD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1] == 1'b0); // R2
endmodule

// File: tb/test_irq_level_ctrl.sv
`timescale 1ns/1ps
module test_irq_level_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic [13:0] src_set = 0;
  logic        ext_lo_n = 1, ext_hi_n = 1;
  logic [2:0]  ipl_n;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_level_ctrl i_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_set(src_set),
    .ext_lo_n(ext_lo_n), .ext_hi_n(ext_hi_n), .ipl_n(ipl_n));

  // {enable[14:0], request[13:0], expected level}
  localparam logic [31:0] VEC [0:11] = '{
    {15'h7FFF, 14'h0001, 3'd1},
    {15'h7FFF, 14'h0030, 3'd3},
    {15'h7FFF, 14'h0440, 3'd4},
    {15'h7FFF, 14'h1800, 3'd5},
    {15'h7FFF, 14'h0084, 3'd4},
    {15'h4001, 14'h0002, 3'd0},
    {15'h4002, 14'h1802, 3'd1},
    {15'h3FFF, 14'h0FFF, 3'd0},
    {15'h4800, 14'h1FFF, 3'd5},
    {15'h7FFF, 14'h0000, 3'd0},
    {15'h4020, 14'h0030, 3'd3},
    {15'h4010, 14'h1FFF, 3'd3}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [15:0] lvl();
    return {13'd0, ~ipl_n};
  endfunction

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ipl", {13'd0, ipl_n}, 16'h0007);
    rd(1, d); chk("R1 en", d, 0);
    rd(3, d); chk("R1 req", d, 0);
    rst_n = 1;
    @(negedge clk);

    // Table walk: R9 R10 R11 R12
    for (int k = 0; k < 12; k++) begin
      wr(0, 16'h7FFF);
      wr(0, {1'b1, VEC[k][31:17]});
      wr(2, 16'h7FFF);
      wr(2, {2'b10, VEC[k][16:3]});
      @(negedge clk);
      chk("R10 level", lvl(), {13'd0, VEC[k][2:0]});
      rd(1, d); chk("R2 en readback", d, {1'b0, VEC[k][31:17]});
      rd(3, d); chk("R5 req readback", d, {2'b0, VEC[k][16:3]});
    end

    // R2 write addresses read as zero
    rd(0, d); chk("R2 addr0 read", d, 0);
    rd(2, d); chk("R2 addr2 read", d, 0);

    // R3 / R4 selective set and clear on enable
    wr(0, 16'h7FFF);
    wr(0, 16'h8003);
    wr(0, 16'h8104);
    rd(1, d); chk("R3 set keeps others", d, 16'h0107);
    wr(0, 16'h0101);
    rd(1, d); chk("R4 clear keeps others", d, 16'h0006);

    // R5 request bit 14 not stored
    wr(2, 16'h3FFF);
    wr(2, 16'hC000);
    rd(3, d); chk("R5 bit14 absent", d, 0);

    // R6 on-chip set pulse; bits 3 and 13 ignored
    src_set = 14'h2009;
    @(negedge clk);
    src_set = 0;
    rd(3, d); chk("R6 pulse", d, 16'h0001);
    // set wins over same-cycle clear
    bus_addr = 2; bus_wdata = 16'h0001; bus_wr = 1; src_set = 14'h0001;
    @(negedge clk);
    bus_wr = 0; src_set = 0;
    rd(3, d); chk("R6 set beats clear", d, 16'h0001);
    wr(2, 16'h0001);

    // R7 external low line: latency and hold
    wr(0, 16'hFFFF);
    ext_lo_n = 0;
    @(negedge clk); @(negedge clk);
    rd(3, d); chk("R7 not yet", d, 0);
    @(negedge clk);
    rd(3, d); chk("R7 set", d, 16'h0008);
    @(negedge clk);
    chk("R7 level 2", lvl(), 16'd2);
    wr(2, 16'h0008);
    rd(3, d); chk("R7 hold despite clear", d, 16'h0008);

    // R8 external high line outranks low
    ext_hi_n = 0;
    repeat (4) @(negedge clk);
    chk("R8 level 6", lvl(), 16'd6);
    rd(3, d); chk("R8 bit13", d, 16'h2008);

    // release and acknowledge
    ext_lo_n = 1; ext_hi_n = 1;
    repeat (3) @(negedge clk);
    wr(2, 16'h2008);
    @(negedge clk);
    chk("R13 idle pins", {13'd0, ipl_n}, 16'h0007);

    // R13 one-edge latency: request set, ipl unchanged until next edge
    bus_addr = 2; bus_wdata = 16'h8800; bus_wr = 1;
    @(posedge clk); #1;
    bus_wr = 0;
    chk("R13 not yet", lvl(), 16'd0);
    @(posedge clk); #1;
    chk("R13 after one edge", lvl(), 16'd5);

    // R12 master off drops level
    @(negedge clk);
    wr(0, 16'h4000);
    @(negedge clk);
    chk("R12 master off", lvl(), 16'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule